// File: doc/BRIEF.md
# Minifloat Adder/Subtractor

This unit adds or subtracts two 8-bit minifloat numbers. The result is normalized, rounded and registered. Each word holds a sign in bit 7, a 3-bit biased exponent in bits 6:4 and a 4-bit fraction in bits 3:0. A word with exponent field e of 1 to 7 and fraction f has the value (-1)^s x (1 + f/16) x 2^(e-3). An exponent field of 0 means zero, whatever the fraction bits hold. The format has no infinity, no NaN and no subnormal encodings.

On each rising clock edge the unit samples both operands and the subtract select. It restores the hidden one of each operand and aligns the smaller magnitude to the larger exponent. Bits shifted out during alignment are kept as guard, round and sticky bits. The unit then adds or subtracts the magnitudes, renormalizes and rounds to nearest, with ties going to even. The packed result appears on the output one cycle after the operands were sampled. Results too large to encode saturate. Results below the smallest normal magnitude flush to zero.

Top module: `e3m4_addsub`

## Requirements
- R1: An operand whose exponent field (bits 6:4) is 0 counts as zero, even when its fraction bits are non-zero. Any other operand has the value (1 + f/16) x 2^(e-3), with bit 7 as its sign.
- R2: While rst_n is low, y is 8'h00. After reset, y holds the result for the a, b and sub values sampled at the previous rising edge of clk.
- R3: When sub is 0, y is a + b rounded to nearest-even. When the two operands have the same sign and both are non-zero, bit 7 of y equals that sign.
- R4: When sub is 1, y is a - b, rounded correctly even when the aligned operand loses bits to the shift, because those bits are kept as sticky information.
- R5: A sum that lies exactly halfway between two representable values rounds to the one with an even fraction. For example, 8'h50 + 8'h18 gives 8'h52, and 8'h51 + 8'h18 also gives 8'h52.
- R6: When the effective operation cancels exactly, y is +0 (8'h00). This includes a - a and a + (-a).
- R7: When the rounded magnitude needs a biased exponent above 7, y saturates to the largest finite magnitude with the result's sign: 8'h7F if positive, 8'hFF if negative.
- R8: A non-zero exact result with magnitude below 2^-2 flushes to zero, keeping the result's sign: 8'h00 if positive, 8'h80 if negative.
- R9: When rounding carries out of the significand, the exponent goes up by one and the fraction becomes zero. For example, 8'h27 + 8'h11 gives 8'h30.
- R10: Adding a zero b to a non-zero a returns a unchanged. Subtracting a non-zero b from zero returns b with its sign flipped.
- R11: y never has exponent field 0 together with a non-zero fraction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; operands are sampled on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| a | input | 8 | First operand |
| b | input | 8 | Second operand |
| sub | input | 1 | 1 computes a - b, 0 computes a + b |
| y | output | 8 | Registered rounded result |

## Verification
The assertions check four properties on every cycle: adding a zero operand returns the other operand (R10), exact cancellation gives +0 (R6), the sign is kept when same-signed operands are added (R3), and a zero exponent field on the output never comes with a non-zero fraction (R11). Exact values are checked by the bench's scenarios, which compare against an exact integer model of the arithmetic. This covers ties to even, sticky-dependent subtraction, rounding carry, saturation and signed flush to zero, which no single-cycle property can cover. The bench runs directed corner cases and a seeded random sweep over all operand encodings, including zero words with non-zero fraction bits.

// File: rtl/e3m4_addsub.sv
module e3m4_addsub (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] a,
  input  logic [7:0] b,
  input  logic       sub,
  output logic [7:0] y
);

  logic       sb;
  logic [4:0] ma, mb;
  logic       swap;
  logic       sl, ss;
  logic [2:0] el, es, d;
  logic [4:0] ml, msm;
  logic [7:0] ext_s, aligned, mask;
  logic       stk;
  logic [8:0] sum;
  logic [3:0] lz;
  logic [7:0] nrm;
  logic signed [5:0] e_n, e_f;
  logic       rup;
  logic [5:0] rnd;
  logic [3:0] frac;
  logic [7:0] res;

  assign sb   = b[7] ^ sub;
  assign ma   = (a[6:4] == 3'd0) ? 5'd0 : {1'b1, a[3:0]};
  assign mb   = (b[6:4] == 3'd0) ? 5'd0 : {1'b1, b[3:0]};
  assign swap = {b[6:4], mb} > {a[6:4], ma};

  assign sl  = swap ? sb : a[7];
  assign ss  = swap ? a[7] : sb;
  assign el  = swap ? b[6:4] : a[6:4];
  assign es  = swap ? a[6:4] : b[6:4];
  assign ml  = swap ? mb : ma;
  assign msm = swap ? ma : mb;
  assign d   = el - es;

  assign ext_s   = {msm, 3'b000};
  assign mask    = (8'd1 << d) - 8'd1;
  assign stk     = |(ext_s & mask);
  assign aligned = (ext_s >> d) | {7'd0, stk};

  assign sum = (sl ^ ss) ? ({1'b0, ml, 3'b000} - {1'b0, aligned})
                         : ({1'b0, ml, 3'b000} + {1'b0, aligned});

  always_comb begin
    lz = 4'd8;
    for (int i = 0; i < 8; i++)
      if (sum[i]) lz = 4'(7 - i);
  end

  always_comb begin
    if (sum[8]) begin
      nrm = {sum[8:2], sum[1] | sum[0]};
      e_n = $signed({3'b000, el}) + 6'sd1;
    end else begin
      nrm = sum[7:0] << lz[2:0];
      e_n = $signed({3'b000, el}) - $signed({2'b00, lz});
    end
  end

  assign rup  = nrm[2] & (nrm[1] | nrm[0] | nrm[3]);
  assign rnd  = {1'b0, nrm[7:3]} + {5'd0, rup};
  assign e_f  = rnd[5] ? (e_n + 6'sd1) : e_n;
  assign frac = rnd[5] ? rnd[4:1] : rnd[3:0];

  always_comb begin
    if (sum == 9'd0)
      res = 8'h00;
    else if (e_f > 6'sd7)
      res = {sl, 7'h7F};
    else if (e_f < 6'sd1)
      res = {sl, 7'h00};
    else
      res = {sl, e_f[2:0], frac};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) y <= 8'h00;
    else        y <= res;
  end

  a_r10_zero_identity: assert property (@(posedge clk) disable iff (!rst_n)
    (b[6:4] == 3'd0 && a[6:4] != 3'd0) |=> (y == $past(a)));

  a_r6_cancel_pos_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (a[6:0] == b[6:0] && (a[7] ^ b[7] ^ sub)) |=> (y == 8'h00));

  a_r3_same_sign: assert property (@(posedge clk) disable iff (!rst_n)
    (a[6:4] != 3'd0 && b[6:4] != 3'd0 && a[7] == (b[7] ^ sub)) |=> (y[7] == $past(a[7])));

  a_r11_canonical_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (y[6:4] == 3'd0) |-> (y[3:0] == 4'd0));

endmodule

// File: tb/e3m4_addsub_tb.sv
module e3m4_addsub_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] a = 8'h00, b = 8'h00;
  logic       sub = 1'b0;
  logic [7:0] y;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  e3m4_addsub u_dut (.clk(clk), .rst_n(rst_n), .a(a), .b(b), .sub(sub), .y(y));

  always #5 clk = ~clk;

  function automatic int mag(input logic [7:0] w);
    if (w[6:4] == 3'd0) return 0;
    return (16 + int'(w[3:0])) << (int'(w[6:4]) - 1);
  endfunction

  function automatic logic [7:0] model(input logic [7:0] x, input logic [7:0] z, input logic s);
    int va, vb, t, m, e, q, quo, rem;
    logic sg;
    va = x[7] ? -mag(x) : mag(x);
    vb = (z[7] ^ s) ? -mag(z) : mag(z);
    t = va + vb;
    if (t == 0) return 8'h00;
    sg = (t < 0);
    m = sg ? -t : t;
    if (m < 16) return {sg, 7'h00};
    e = 1;
    while (m >= (32 << (e - 1))) e++;
    q = 1 << (e - 1);
    quo = m / q;
    rem = m % q;
    if (rem * 2 > q || (rem * 2 == q && quo[0])) quo++;
    if (quo == 32) begin quo = 16; e++; end
    if (e > 7) return {sg, 7'h7F};
    return {sg, 3'(e), 4'(quo - 16)};
  endfunction

  task automatic run(input logic [7:0] x, input logic [7:0] z, input logic s,
                     input logic [7:0] exp_v, input string tag);
    @(negedge clk);
    a = x; b = z; sub = s;
    @(negedge clk);
    n_chk++;
    if (y !== exp_v) begin
      n_bad++;
      $display("FAIL %s: a=%h b=%h sub=%0b actual=%h expected=%h", tag, x, z, s, y, exp_v);
    end
  endtask

  task automatic run_m(input logic [7:0] x, input logic [7:0] z, input logic s, input string tag);
    run(x, z, s, model(x, z, s), tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    n_chk++;
    if (y !== 8'h00) begin
      n_bad++;
      $display("FAIL R2 reset: actual=%h expected=00", y);
    end
    rst_n = 1'b1;

    run(8'h30, 8'h30, 1'b0, 8'h40, "R3 1+1");
    run(8'h35, 8'h42, 1'b0, model(8'h35, 8'h42, 1'b0), "R3 mixed exp");
    run(8'h50, 8'h18, 1'b0, 8'h52, "R5 tie up to even");
    run(8'h51, 8'h18, 1'b0, 8'h52, "R5 tie down to even");
    run(8'h27, 8'h11, 1'b0, 8'h30, "R9 rounding carry");
    run(8'h70, 8'h11, 1'b1, model(8'h70, 8'h11, 1'b1), "R4 sticky subtract");
    run(8'h40, 8'h11, 1'b1, model(8'h40, 8'h11, 1'b1), "R4 borrow subtract");
    run(8'h45, 8'h45, 1'b1, 8'h00, "R6 a-a");
    run(8'hC5, 8'h45, 1'b0, 8'h00, "R6 -a+a");
    run(8'h7F, 8'h7F, 1'b0, 8'h7F, "R7 pos saturate");
    run(8'hFF, 8'h7F, 1'b1, 8'hFF, "R7 neg saturate");
    run(8'h11, 8'h10, 1'b1, 8'h00, "R8 pos flush");
    run(8'h10, 8'h11, 1'b1, 8'h80, "R8 neg flush");
    run(8'h05, 8'h30, 1'b0, 8'h30, "R1 zero with fraction bits");
    run(8'h8F, 8'h0A, 1'b1, 8'h00, "R1 two zero words");
    run(8'h00, 8'h30, 1'b1, 8'hB0, "R10 zero minus b");
    run(8'h63, 8'h80, 1'b0, 8'h63, "R10 a plus zero");

    void'($urandom(32'd1234));
    for (int i = 0; i < 3000; i++) begin
      logic [7:0] x, z;
      logic s;
      x = 8'($urandom);
      z = 8'($urandom);
      s = 1'($urandom);
      run_m(x, z, s, s ? "R4 random" : "R3 random");
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL R2 watchdog: actual=hung expected=done");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule